// File: doc/BRIEF.md
# Counter-Sequence Input Monitor

This block watches a 16-bit word stream, such as the output of a link deserializer or a trigger decision word, and does two things with it in parallel. It copies the received words into an external capture memory through a registered write port, starting at address 0 each time acquisition is started. At the same time it checks every valid word against a counter that it runs itself. It keeps a saturating 16-bit tally of mismatches and a 48-bit tally of all valid words.

Acquisition starts on a one-cycle `start` pulse, which software or a debounced push button can raise. It ends by itself once the 32768-word memory is full, and `capture_done` then reports completion. A `sync` pulse marks the point where the upstream source restarts its sequence at zero. After any valid word the local counter takes that word plus one. A jump in the sequence therefore costs one error rather than a stream of them.

Top module: `rxseq_monitor`

## Requirements
- R1: While reset is asserted and after its release, `mem_we`, `mem_addr`, `mem_wdata`, `err_count`, `word_count` and `capture_done` are all zero.
- R2: After a `start` pulse, each cycle with `rx_valid` high produces one memory write in the next cycle: `mem_we` is 1, `mem_wdata` equals that word, and `mem_addr` runs 0, 1, 2, … in arrival order. A word that arrives in the same cycle as `start` is not written.
- R3: No write happens while acquisition is not armed, and none happens for a cycle in which `rx_valid` is low.
- R4: The write to address 32767 (the last 15-bit address) disarms capture, and `capture_done` rises in the same cycle as that write. Later valid words are not written. A new `start` clears `capture_done` in the next cycle and restarts writing at address 0.
- R5: `word_count` rises by exactly 1 in the cycle after each cycle with `rx_valid` high and is unchanged otherwise. Invalid words are neither counted nor checked.
- R6: Each valid word is compared with the expected value, which is 0 after reset. A difference raises `err_count` by 1 in the next cycle.
- R7: After every valid word the expected value becomes that word plus 1, modulo 2^16, so 0xFFFF is followed by 0x0000. A jump such as 2, 16, 17 costs one error; a single corrupted word inside a correct sequence costs two.
- R8: `sync` forces the expected value to 0. A valid word in the same cycle as `sync` is compared with 0, and a `sync` with no valid word makes the next valid word be expected as 0.
- R9: `err_count` stops at 0xFFFF and stays there while further mismatches arrive.
- R10: `clr_cnt` zeroes `err_count` and `word_count` in the next cycle, even if a valid word or a mismatch arrives in that cycle. It does not alter the expected value or the capture path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 16 | Received word |
| rx_valid | input | 1 | Marks `rx_data` as a received word |
| start | input | 1 | One-cycle pulse that arms capture from address 0 |
| sync | input | 1 | Sequence restart marker; the expected value becomes 0 |
| clr_cnt | input | 1 | Zeroes the error and word tallies |
| mem_we | output | 1 | Capture memory write enable |
| mem_addr | output | 15 | Capture memory write address |
| mem_wdata | output | 16 | Capture memory write data |
| err_count | output | 16 | Saturating mismatch tally |
| word_count | output | 48 | Valid word tally |
| capture_done | output | 1 | Memory filled; capture has stopped |

## Verification
The bench sends sequences with jumps, a single corrupted word, a wrap from 0xFFFF to 0x0000, `sync` with and without a word in the same cycle, and invalid gaps, and it checks both tallies after each word. If the design compared against a counter that keeps running instead of reloading, the jump case would count an error on every later word. If it ignored the `sync`-with-word case, one error too many or too few would show up. It fills the whole memory to check that the last address is 32767, that later words are dropped and that a new `start` clears `capture_done`; an off-by-one design would either wrap into address 0 or stop one word early. It then drives more than 65535 mismatches to confirm the error tally holds at 0xFFFF rather than wrapping to a small value. It also raises `clr_cnt` in a cycle with a valid word, where an increment that wins over the clear would leave a count of 1.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;
  localparam int SEQ_W  = 16;
  localparam int ERR_W  = 16;
  localparam int WCNT_W = 48;
  localparam int ADDR_W = 15;

  // value the next word should carry after this one
  function automatic logic [SEQ_W-1:0] next_expected(input logic [SEQ_W-1:0] word);
    return word + SEQ_W'(1);
  endfunction

  // reference value for this cycle: a sync marker means the sequence restarts at 0
  function automatic logic [SEQ_W-1:0] cmp_ref(input logic [SEQ_W-1:0] expect_q,
                                               input logic              sync_now);
    return sync_now ? '0 : expect_q;
  endfunction

  // increment that sticks at all ones
  function automatic logic [ERR_W-1:0] sat_inc(input logic [ERR_W-1:0] v);
    return (&v) ? v : v + ERR_W'(1);
  endfunction
endpackage

// File: rtl/rxseq_seq_check.sv
module rxseq_seq_check
  import rxseq_pkg::*;
#(
  parameter int DW = SEQ_W,
  parameter int EW = ERR_W,
  parameter int CW = WCNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic          sync,
  input  logic          clr_cnt,
  output logic          miss,
  output logic [EW-1:0] err_count,
  output logic [CW-1:0] word_count
);
  logic [DW-1:0] expect_q;
  logic [DW-1:0] ref_now;

  always_comb begin
    ref_now = cmp_ref(expect_q, sync);
    miss    = rx_valid && (rx_data != ref_now);
  end

  // expected value: reload from every valid word, zero on a bare sync
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        expect_q <= '0;
    else if (rx_valid) expect_q <= next_expected(rx_data);
    else if (sync)     expect_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count  <= '0;
      word_count <= '0;
    end else if (clr_cnt) begin
      err_count  <= '0;
      word_count <= '0;
    end else begin
      if (rx_valid) word_count <= word_count + CW'(1);
      if (miss)     err_count  <= sat_inc(err_count);
    end
  end
endmodule

// File: rtl/rxseq_capture.sv
module rxseq_capture
  import rxseq_pkg::*;
#(
  parameter int DW = SEQ_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic          start,
  output logic          armed,
  output logic          wr_evt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          capture_done
);
  localparam logic [AW-1:0] LAST_ADDR = '1;

  logic [AW-1:0] wr_ptr;

  assign wr_evt = armed && rx_valid && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      wr_ptr       <= '0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      capture_done <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (start) begin
        armed        <= 1'b1;
        wr_ptr       <= '0;
        capture_done <= 1'b0;
      end else if (wr_evt) begin
        mem_we    <= 1'b1;
        mem_addr  <= wr_ptr;
        mem_wdata <= rx_data;
        wr_ptr    <= wr_ptr + AW'(1);
        if (wr_ptr == LAST_ADDR) begin
          armed        <= 1'b0;
          capture_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxseq_monitor.sv
module rxseq_monitor
  import rxseq_pkg::*;
#(
  parameter int DW = SEQ_W,
  parameter int AW = ADDR_W,
  parameter int EW = ERR_W,
  parameter int CW = WCNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic          start,
  input  logic          sync,
  input  logic          clr_cnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [EW-1:0] err_count,
  output logic [CW-1:0] word_count,
  output logic          capture_done
);
  // internal events brought out for the checker
  logic chk_miss;
  logic cap_armed;
  logic cap_wr_evt;

  rxseq_seq_check #(.DW(DW), .EW(EW), .CW(CW)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .sync       (sync),
    .clr_cnt    (clr_cnt),
    .miss       (chk_miss),
    .err_count  (err_count),
    .word_count (word_count)
  );

  rxseq_capture #(.DW(DW), .AW(AW)) u_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .start        (start),
    .armed        (cap_armed),
    .wr_evt       (cap_wr_evt),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .capture_done (capture_done)
  );
endmodule

// File: rtl/rxseq_monitor_sva.sv
module rxseq_monitor_sva #(
  parameter int AW = 15,
  parameter int EW = 16,
  parameter int CW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          start,
  input logic          clr_cnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [EW-1:0] err_count,
  input logic [CW-1:0] word_count,
  input logic          capture_done,
  input logic          chk_miss,
  input logic          cap_armed,
  input logic          cap_wr_evt
);
  assert_write_from_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(rx_valid) && !$past(start)));

  assert_no_write_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_armed || !rx_valid) |=> !mem_we);

  assert_done_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_done) |-> (mem_we && (&mem_addr)));

  assert_silent_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_done |=> !mem_we);

  assert_word_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cnt |=> word_count == $past(word_count) + CW'($past(rx_valid)));

  assert_miss_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_miss && !clr_cnt && !(&err_count)) |=> err_count == $past(err_count) + EW'(1));

  assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_miss && !clr_cnt) |=> $stable(err_count));

  assert_err_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&err_count) && !clr_cnt) |=> (&err_count));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> (word_count == '0 && err_count == '0));

  assert_wr_evt_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_wr_evt |-> rx_valid);
endmodule

bind rxseq_monitor rxseq_monitor_sva #(.AW(AW), .EW(EW), .CW(CW)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .start        (start),
  .clr_cnt      (clr_cnt),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .err_count    (err_count),
  .word_count   (word_count),
  .capture_done (capture_done),
  .chk_miss     (chk_miss),
  .cap_armed    (cap_armed),
  .cap_wr_evt   (cap_wr_evt)
);

// File: tb/rxseq_monitor_tb.sv
module rxseq_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        start = 1'b0;
  logic        sync = 1'b0;
  logic        clr_cnt = 1'b0;
  logic        mem_we;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] err_count;
  logic [47:0] word_count;
  logic        capture_done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rxseq_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .start(start), .sync(sync), .clr_cnt(clr_cnt),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .err_count(err_count), .word_count(word_count), .capture_done(capture_done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle's inputs just after a falling edge, return at the next falling edge
  task automatic cyc(input bit v, input bit s, input logic [15:0] d, input bit st, input bit clr);
    rx_valid = v; sync = s; rx_data = d; start = st; clr_cnt = clr;
    @(negedge clk);
    rx_valid = 1'b0; sync = 1'b0; start = 1'b0; clr_cnt = 1'b0;
  endtask

  // {valid, sync, data, err after, words after}
  localparam int NV = 18;
  localparam logic [49:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'h0000, 16'd0, 16'd1},
    {1'b1, 1'b0, 16'h0001, 16'd0, 16'd2},
    {1'b1, 1'b0, 16'h0002, 16'd0, 16'd3},
    {1'b0, 1'b0, 16'h0003, 16'd0, 16'd3},
    {1'b1, 1'b0, 16'h0003, 16'd0, 16'd4},
    {1'b1, 1'b0, 16'h0010, 16'd1, 16'd5},
    {1'b1, 1'b0, 16'h0011, 16'd1, 16'd6},
    {1'b1, 1'b0, 16'h0063, 16'd2, 16'd7},
    {1'b1, 1'b0, 16'h0012, 16'd3, 16'd8},
    {1'b1, 1'b0, 16'h0013, 16'd3, 16'd9},
    {1'b1, 1'b1, 16'h0000, 16'd3, 16'd10},
    {1'b1, 1'b0, 16'h0001, 16'd3, 16'd11},
    {1'b0, 1'b1, 16'h0000, 16'd3, 16'd11},
    {1'b1, 1'b0, 16'h0000, 16'd3, 16'd12},
    {1'b1, 1'b0, 16'hFFFF, 16'd4, 16'd13},
    {1'b1, 1'b0, 16'h0000, 16'd4, 16'd14},
    {1'b1, 1'b1, 16'h0005, 16'd5, 16'd15},
    {1'b1, 1'b0, 16'h0006, 16'd5, 16'd16}
  };

  initial begin
    #(20 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int exp_addr;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    check(!mem_we && mem_addr == 0 && mem_wdata == 0, "R1 write port in reset", mem_we, 0);
    check(err_count == 0 && word_count == 0 && !capture_done, "R1 tallies in reset", word_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(err_count == 0 && word_count == 0 && !mem_we && !capture_done, "R1 after release", err_count, 0);

    // R3: a valid word before any start is not written
    cyc(1, 0, 16'h0000, 0, 0);
    check(!mem_we, "R3 no write before start", mem_we, 0);
    // R10/R8: clear tallies and restart the expected sequence
    cyc(0, 1, 16'h0000, 0, 1);
    check(word_count == 0 && err_count == 0, "R10 clear", word_count, 0);

    // R2: a word in the start cycle is not written
    cyc(1, 0, 16'h0000, 1, 0);
    check(!mem_we, "R2 no write in start cycle", mem_we, 0);
    cyc(1, 1, 16'h0000, 0, 1);  // bring tallies and expected value back to a known state
    check(word_count == 0 && err_count == 0 && mem_we && mem_addr == 0, "R10 clear over valid", word_count, 0);
    cyc(0, 1, 16'h0000, 1, 0);  // re-arm at address 0 with the expected value at 0
    exp_addr = 0;

    // table walk: R5 R6 R7 R8 and R2/R3 write port
    for (int i = 0; i < NV; i++) begin
      logic [49:0] e;
      e = VEC[i];
      cyc(e[49], e[48], e[47:32], 0, 0);
      check(err_count == e[31:16], $sformatf("R6/R7/R8 err vec %0d", i), err_count, e[31:16]);
      check(word_count == 48'(e[15:0]), $sformatf("R5 words vec %0d", i), word_count, e[15:0]);
      check(mem_we == e[49], $sformatf("R2/R3 we vec %0d", i), mem_we, e[49]);
      if (e[49]) begin
        check(mem_addr == 15'(exp_addr) && mem_wdata == e[47:32],
              $sformatf("R2 addr/data vec %0d", i), {mem_addr, mem_wdata}, {15'(exp_addr), e[47:32]});
        exp_addr++;
      end
    end

    // R10: clear wins over a matching valid word and keeps the expected value
    cyc(1, 0, 16'h0007, 0, 1);
    check(word_count == 0 && err_count == 0, "R10 clear wins", word_count, 0);
    check(mem_we && mem_wdata == 16'h0007, "R10 capture unaffected", mem_wdata, 16'h0007);
    cyc(1, 0, 16'h0008, 0, 0);
    check(err_count == 0 && word_count == 1, "R10 expected kept", err_count, 0);

    // R4: fill the memory from a fresh start
    cyc(0, 0, 16'h0000, 1, 0);
    for (int i = 0; i < 32768; i++) begin
      cyc(1, 0, 16'(i), 0, 0);
      if (i == 0)
        check(mem_we && mem_addr == 0, "R4 restart at 0", mem_addr, 0);
      if (i == 32766)
        check(!capture_done && mem_addr == 15'h7FFE, "R4 not done early", capture_done, 0);
      if (i == 32767)
        check(capture_done && mem_we && mem_addr == 15'h7FFF, "R4 done on last write", mem_addr, 15'h7FFF);
    end
    cyc(1, 0, 16'h1234, 0, 0);
    check(!mem_we && capture_done, "R4 no write after done", mem_we, 0);
    cyc(0, 0, 16'h0000, 1, 0);
    check(!capture_done, "R4 start clears done", capture_done, 0);
    cyc(1, 0, 16'hBEEF, 0, 0);
    check(mem_we && mem_addr == 0 && mem_wdata == 16'hBEEF, "R4 rewrite from 0", mem_addr, 0);

    // R9: error tally saturation
    cyc(0, 1, 16'h0000, 0, 1);
    for (int i = 0; i < 65540; i++) begin
      cyc(1, 0, 16'h5555, 0, 0);
      if (i == 65533) check(err_count == 16'hFFFE, "R9 one below limit", err_count, 16'hFFFE);
      if (i == 65534) check(err_count == 16'hFFFF, "R9 reach limit", err_count, 16'hFFFF);
    end
    check(err_count == 16'hFFFF, "R9 holds at limit", err_count, 16'hFFFF);
    check(word_count == 48'd65540, "R5 words past 16 bits", word_count, 65540);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule